// File: doc/BRIEF.md
# PIPE Lane Rate and Power Sequencer

This block is the per-lane control point between a link-layer MAC and one serial transceiver channel. The MAC presents three requests: a 2-bit line-rate code, a 2-bit power-state code and a transmit electrical-idle flag. The block watches the rate code for the two transitions that move the lane between 2.5 Gbps (Gen1) and 5 Gbps (Gen2). When it sees one, it asks the channel to change rate, waits for the channel's done handshake and then reports the new rate. It also follows the requested power state, and keeps the transmitter buffer in electrical idle whenever the lane is outside P0 or the MAC asks for idle. A single-cycle status pulse tells the MAC that a rate switch has finished or that a power change has settled.

Two state machines carry the work. The rate machine has the states RS_IDLE (no switch), RS_WAIT (request held to the channel until it answers) and RS_DONE (one cycle that reports completion). Its transitions are: start (RS_IDLE to RS_WAIT, on a detected transition or a held one), answer (RS_WAIT to RS_DONE, on channel done) and retire (RS_DONE to RS_IDLE). The power machine has the states PS_STEADY, PS_SETTLE and PS_DONE. Its transitions are: change (PS_STEADY to PS_SETTLE, when the request differs from the tracked state), settled (PS_SETTLE to PS_DONE, when the settle counter reaches its limit) and retire (PS_DONE to PS_STEADY).

Top module: `pipe_rate_pwr_ctrl`

## Requirements
- R1: A synchronous active-high reset gives cur_rate=0 (Gen1), cur_pwr=2'b00 (P0), tx_elec_idle=1, chan_rate_chg=0, phy_status=0, and no held rate request.
- R2: When req_rate goes from 2'b00 on one sampled edge to 2'b01 on the next, and cur_rate is 0, chan_rate_chg rises after that edge. It stays high until the edge on which chan_rate_done is sampled high, and on that edge cur_rate becomes 1 (Gen2) and chan_rate_chg falls.
- R3: When req_rate goes from 2'b01 to 2'b00 and cur_rate is 1, the same handshake runs and cur_rate becomes 0 (Gen1).
- R4: The codes 2'b10 and 2'b11, and any change other than 2'b00 to 2'b01 or 2'b01 to 2'b00, start no switch. A defined transition whose target equals cur_rate also starts no switch. In all these cases cur_rate, chan_rate_chg and phy_status stay unchanged.
- R5: A completed rate switch raises phy_status for exactly one cycle, the first cycle in which cur_rate shows the new rate.
- R6: A defined rate transition seen while a switch is running is held. The idle state starts it on the second edge after the running switch reports completion, so its status pulse comes five cycles after the first one when the channel answers after three cycles of request.
- R7: cur_pwr takes the value of req_pwr (P0=2'b00, P0s=2'b01, P1=2'b10, P2=2'b11) on the edge after the request differs from it. A further change made while a power change is settling does not alter cur_pwr until the machine is back in PS_STEADY.
- R8: A power change raises phy_status for exactly one cycle, SETTLE_CYC cycles after cur_pwr takes the new value.
- R9: tx_elec_idle is a register loaded each cycle with req_txidle OR (cur_pwr != 2'b00). It is therefore 1 one cycle after the lane enters P0s, P1 or P2, whatever req_txidle is.
- R10: phy_status is high only in the cycles named by R5 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| req_rate | input | 2 | Rate request from the MAC (2'b00 Gen1, 2'b01 Gen2) |
| req_pwr | input | 2 | Power-state request from the MAC |
| req_txidle | input | 1 | Transmit electrical-idle request from the MAC |
| chan_rate_done | input | 1 | Channel reports that the rate change finished |
| chan_rate_chg | output | 1 | Rate-change request to the channel |
| cur_rate | output | 1 | Current line rate, 0 Gen1, 1 Gen2 |
| cur_pwr | output | 2 | Current power state |
| tx_elec_idle | output | 1 | Electrical-idle control to the transmitter buffer |
| phy_status | output | 1 | One-cycle completion pulse to the MAC |

## Verification
The rate function is driven with the two defined transitions, which must each produce a switch in the right direction. It also gets the undefined codes 2'b10 and 2'b11 in both directions, to show that only the exact code pairs trigger. A defined transition toward the rate already in use shows that the target is compared with the current rate and not only with the code edge. A reversal issued one cycle into a running switch shows that a request is held and not dropped, and that it is not merged into the switch already running. The power function steps through each low-power state and back to P0, which separates forced idle from the MAC's own idle request. A change made in mid-settle shows that the tracked state stays frozen until the first change has reported.

// File: rtl/pipe_rpc_pkg.sv
package pipe_rpc_pkg;

    localparam int unsigned RATE_W = 2;
    localparam int unsigned PWR_W  = 2;

    localparam logic [RATE_W-1:0] RATE_CODE_GEN1 = 2'b00;
    localparam logic [RATE_W-1:0] RATE_CODE_GEN2 = 2'b01;

    localparam logic [PWR_W-1:0] PWR_P0  = 2'b00;
    localparam logic [PWR_W-1:0] PWR_P0S = 2'b01;
    localparam logic [PWR_W-1:0] PWR_P1  = 2'b10;
    localparam logic [PWR_W-1:0] PWR_P2  = 2'b11;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_WAIT = 2'd1,
        RS_DONE = 2'd2
    } rate_fsm_e;

    typedef enum logic [1:0] {
        PS_STEADY = 2'd0,
        PS_SETTLE = 2'd1,
        PS_DONE   = 2'd2
    } pwr_fsm_e;

endpackage

// File: rtl/rpc_rate_edge.sv
module rpc_rate_edge
    import pipe_rpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] req_rate,
    output logic              hit,
    output logic              hit_tgt
);

    logic [RATE_W-1:0] prev_q;
    logic              up_edge;
    logic              dn_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= RATE_CODE_GEN1;
        end else begin
            prev_q <= req_rate;
        end
    end

    always_comb begin
        up_edge = (prev_q == RATE_CODE_GEN1) && (req_rate == RATE_CODE_GEN2);
        dn_edge = (prev_q == RATE_CODE_GEN2) && (req_rate == RATE_CODE_GEN1);
        hit     = up_edge || dn_edge;
        hit_tgt = up_edge;
    end

    // R4: a code outside the two defined values never yields a transition
    a_r4_undefined_code_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_rate[1] == 1'b1) |-> !hit);

endmodule

// File: rtl/rpc_rate_seq.sv
module rpc_rate_seq
    import pipe_rpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic hit_tgt,
    input  logic chan_done,
    output logic chan_chg,
    output logic cur_rate,
    output logic done_pulse
);

    rate_fsm_e state_q;
    rate_fsm_e state_d;
    logic      tgt_q;
    logic      tgt_d;
    logic      cur_q;
    logic      cur_d;
    logic      pend_v_q;
    logic      pend_v_d;
    logic      pend_t_q;
    logic      pend_t_d;
    logic      start_new;
    logic      start_held;

    always_comb begin
        start_new  = hit && (hit_tgt != cur_q);
        start_held = !hit && pend_v_q && (pend_t_q != cur_q);
    end

    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        cur_d    = cur_q;
        pend_v_d = pend_v_q;
        pend_t_d = pend_t_q;
        unique case (state_q)
            RS_IDLE: begin
                pend_v_d = 1'b0;
                if (start_new) begin
                    state_d = RS_WAIT;
                    tgt_d   = hit_tgt;
                end else if (start_held) begin
                    state_d = RS_WAIT;
                    tgt_d   = pend_t_q;
                end
            end
            RS_WAIT: begin
                if (hit) begin
                    pend_v_d = 1'b1;
                    pend_t_d = hit_tgt;
                end
                if (chan_done) begin
                    state_d = RS_DONE;
                    cur_d   = tgt_q;
                end
            end
            RS_DONE: begin
                if (hit) begin
                    pend_v_d = 1'b1;
                    pend_t_d = hit_tgt;
                end
                state_d = RS_IDLE;
            end
            default: begin
                state_d = RS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RS_IDLE;
            tgt_q    <= 1'b0;
            cur_q    <= 1'b0;
            pend_v_q <= 1'b0;
            pend_t_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            tgt_q    <= tgt_d;
            cur_q    <= cur_d;
            pend_v_q <= pend_v_d;
            pend_t_q <= pend_t_d;
        end
    end

    always_comb begin
        chan_chg   = 1'b0;
        done_pulse = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_WAIT: chan_chg   = 1'b1;
            RS_DONE: done_pulse = 1'b1;
            default: ;
        endcase
        cur_rate = cur_q;
    end

    // R2: the request to the channel is held until the channel answers
    a_r2_hold_request: assert property (@(posedge clk) disable iff (rst)
        (chan_chg && !chan_done) |=> chan_chg);

    // R2/R3: the reported rate moves only on a channel answer
    a_r2_rate_moves_on_done: assert property (@(posedge clk) disable iff (rst)
        (cur_rate != $past(cur_rate)) |-> $past(chan_chg && chan_done));

    // R5: completion status lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    // R6: a transition arriving mid-switch is kept
    a_r6_request_held: assert property (@(posedge clk) disable iff (rst)
        (chan_chg && hit) |=> pend_v_q);

endmodule

// File: rtl/rpc_pwr_track.sv
module rpc_pwr_track
    import pipe_rpc_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [PWR_W-1:0] req_pwr,
    output logic [PWR_W-1:0] cur_pwr,
    output logic             done_pulse
);

    localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    pwr_fsm_e         state_q;
    pwr_fsm_e         state_d;
    logic [PWR_W-1:0] pwr_q;
    logic [PWR_W-1:0] pwr_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        state_d = state_q;
        pwr_d   = pwr_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_STEADY: begin
                if (req_pwr != pwr_q) begin
                    state_d = PS_SETTLE;
                    pwr_d   = req_pwr;
                    cnt_d   = '0;
                end
            end
            PS_SETTLE: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = PS_DONE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PS_DONE: begin
                state_d = PS_STEADY;
            end
            default: begin
                state_d = PS_STEADY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_STEADY;
            pwr_q   <= PWR_P0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pwr_q   <= pwr_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        done_pulse = 1'b0;
        unique case (state_q)
            PS_STEADY: ;
            PS_SETTLE: ;
            PS_DONE:   done_pulse = 1'b1;
            default:   ;
        endcase
        cur_pwr = pwr_q;
    end

    // R7: the tracked state is frozen while a change settles
    a_r7_frozen_while_settling: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_STEADY) |=> $stable(cur_pwr));

    // R8: completion comes only after the full settle count
    a_r8_full_count: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> ($past(cnt_q) == CNT_LAST));

    // R8: completion status lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

endmodule

// File: rtl/rpc_idle_gate.sv
module rpc_idle_gate
    import pipe_rpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_txidle,
    input  logic [PWR_W-1:0] cur_pwr,
    output logic             tx_idle
);

    logic low_power;
    logic idle_q;

    always_comb begin
        low_power = (cur_pwr != PWR_P0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b1;
        end else begin
            idle_q <= req_txidle || low_power;
        end
    end

    always_comb begin
        tx_idle = idle_q;
    end

    // R9: any low-power state forces idle on the next cycle
    a_r9_low_power_forces_idle: assert property (@(posedge clk) disable iff (rst)
        (cur_pwr != PWR_P0) |=> tx_idle);

endmodule

// File: rtl/pipe_rate_pwr_ctrl.sv
module pipe_rate_pwr_ctrl
    import pipe_rpc_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 8
)(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req_rate,
    input  logic [1:0] req_pwr,
    input  logic       req_txidle,
    input  logic       chan_rate_done,
    output logic       chan_rate_chg,
    output logic       cur_rate,
    output logic [1:0] cur_pwr,
    output logic       tx_elec_idle,
    output logic       phy_status
);

    logic hit;
    logic hit_tgt;
    logic rate_done;
    logic pwr_done;

    rpc_rate_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .req_rate (req_rate),
        .hit      (hit),
        .hit_tgt  (hit_tgt)
    );

    rpc_rate_seq u_rate (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .hit_tgt    (hit_tgt),
        .chan_done  (chan_rate_done),
        .chan_chg   (chan_rate_chg),
        .cur_rate   (cur_rate),
        .done_pulse (rate_done)
    );

    rpc_pwr_track #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
        .clk        (clk),
        .rst        (rst),
        .req_pwr    (req_pwr),
        .cur_pwr    (cur_pwr),
        .done_pulse (pwr_done)
    );

    rpc_idle_gate u_idle (
        .clk        (clk),
        .rst        (rst),
        .req_txidle (req_txidle),
        .cur_pwr    (cur_pwr),
        .tx_idle    (tx_elec_idle)
    );

    always_comb begin
        phy_status = rate_done || pwr_done;
    end

    // R1: reset leaves the transmitter idle at Gen1 in P0
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_elec_idle && !cur_rate && (cur_pwr == PWR_P0) && !chan_rate_chg));

endmodule

// File: tb/tb_pipe_rate_pwr_ctrl.sv
module tb_pipe_rate_pwr_ctrl;

    localparam int S   = 6;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] req_rate;
    logic [1:0] req_pwr;
    logic       req_txidle;
    logic       chan_rate_done;
    logic       chan_rate_chg;
    logic       cur_rate;
    logic [1:0] cur_pwr;
    logic       tx_elec_idle;
    logic       phy_status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_q[$];
    bit finished = 0;

    always #2 clk = ~clk;

    pipe_rate_pwr_ctrl #(.SETTLE_CYC(S)) dut (
        .clk            (clk),
        .rst            (rst),
        .req_rate       (req_rate),
        .req_pwr        (req_pwr),
        .req_txidle     (req_txidle),
        .chan_rate_done (chan_rate_done),
        .chan_rate_chg  (chan_rate_chg),
        .cur_rate       (cur_rate),
        .cur_pwr        (cur_pwr),
        .tx_elec_idle   (tx_elec_idle),
        .phy_status     (phy_status)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // channel model: answers after LAT cycles of request
    int resp_n = 0;
    always @(negedge clk) begin
        if (rst || !chan_rate_chg) begin
            resp_n = 0;
            chan_rate_done = 1'b0;
        end else begin
            resp_n++;
            chan_rate_done = (resp_n == LAT);
        end
    end

    // scoreboard monitor: every status pulse must match the head of the queue
    always @(negedge clk) begin
        if (!rst && phy_status) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected status pulse cycle", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R5/R8/R10 status pulse cycle", cyc, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int k;
        rst = 1'b1; req_rate = 2'b00; req_pwr = 2'b00; req_txidle = 1'b1;
        step(3);
        chk("R1 reset cur_rate", cur_rate, 0);
        chk("R1 reset cur_pwr", cur_pwr, 0);
        chk("R1 reset tx_elec_idle", tx_elec_idle, 1);
        chk("R1 reset chan_rate_chg", chan_rate_chg, 0);
        chk("R1 reset phy_status", phy_status, 0);
        rst = 1'b0;
        step(1);

        // R9 idle follows the MAC request in P0
        req_txidle = 1'b0; step(1);
        chk("R9 idle released in P0", tx_elec_idle, 0);
        req_txidle = 1'b1; step(1);
        chk("R9 idle requested in P0", tx_elec_idle, 1);
        req_txidle = 1'b0; step(2);

        // R2 Gen1 -> Gen2
        req_rate = 2'b01; k = cyc; exp_q.push_back(k + LAT + 1);
        step(1);
        chk("R2 request raised", chan_rate_chg, 1);
        chk("R2 rate unchanged while waiting", cur_rate, 0);
        step(LAT);
        chk("R2 rate now Gen2", cur_rate, 1);
        chk("R2 request dropped", chan_rate_chg, 0);
        step(4);

        // R3 Gen2 -> Gen1
        req_rate = 2'b00; k = cyc; exp_q.push_back(k + LAT + 1);
        step(1);
        chk("R3 request raised", chan_rate_chg, 1);
        step(LAT);
        chk("R3 rate now Gen1", cur_rate, 0);
        step(4);

        // R4 undefined codes and same-target transition
        req_rate = 2'b10; step(6);
        chk("R4 code 10 no request", chan_rate_chg, 0);
        chk("R4 code 10 rate kept", cur_rate, 0);
        req_rate = 2'b01; step(6);
        chk("R4 10->01 rate kept", cur_rate, 0);
        req_rate = 2'b00; step(6);
        chk("R4 same-target 01->00 rate kept", cur_rate, 0);
        chk("R4 same-target no request", chan_rate_chg, 0);
        req_rate = 2'b11; step(3);
        req_rate = 2'b00; step(3);
        chk("R4 11->00 rate kept", cur_rate, 0);
        req_rate = 2'b01; k = cyc; exp_q.push_back(k + LAT + 1);
        step(LAT + 4);
        chk("R2 second switch to Gen2", cur_rate, 1);

        // R6 reversal held during a running switch
        req_rate = 2'b00; k = cyc;
        exp_q.push_back(k + LAT + 1);
        exp_q.push_back(k + LAT + 6);
        step(1);
        req_rate = 2'b01;
        step(4);
        chk("R6 first switch finished at Gen1", cur_rate, 0);
        step(6);
        chk("R6 held switch back to Gen2", cur_rate, 1);
        chk("R6 request dropped at end", chan_rate_chg, 0);
        step(2);

        // R7 R8 R9 each low-power state and back
        for (int p = 1; p < 4; p++) begin
            req_pwr = 2'(p); k = cyc; exp_q.push_back(k + 1 + S);
            step(1);
            chk("R7 cur_pwr follows request", cur_pwr, p);
            step(1);
            chk("R9 low power forces idle", tx_elec_idle, 1);
            step(S);
            req_pwr = 2'b00; k = cyc; exp_q.push_back(k + 1 + S);
            step(2);
            chk("R9 idle released back in P0", tx_elec_idle, 0);
            step(S + 1);
        end

        // R7 change during settle waits
        req_pwr = 2'b11; k = cyc;
        exp_q.push_back(k + 1 + S);
        exp_q.push_back(k + 3 + 2 * S);
        step(2);
        req_pwr = 2'b01;
        step(1);
        chk("R7 cur_pwr frozen while settling", cur_pwr, 3);
        step(2 * S + 3);
        chk("R7 later request applied", cur_pwr, 1);
        req_pwr = 2'b00; k = cyc; exp_q.push_back(k + 1 + S);
        step(S + 4);
        chk("R7 back in P0", cur_pwr, 0);

        step(4);
        chk("R10 all expected pulses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule